// File: doc/BRIEF.md
# Bus-Level Evolvable Functional-Unit Array

This block is a combinational array of small configurable 4-bit functional units. A configuration string sets both the wiring and the function of every unit. Each unit is either a bitwise AND or a ripple adder. Each of its two operands comes from a primary input or from the result of an earlier unit. An operand is taken either as a whole 4-bit bus or as one chosen bit copied onto all four lanes. Reading a 5-bit unit result through its upper window gives a one-place shift. The primary inputs are two 4-bit operands, each offered in four identical slots, plus a constant one and a constant zero. The last eight units also act as taps, and each tap drives one bit of the 8-bit result. A search engine that sits outside this block uses it to try candidate circuits, such as a 4x4 multiplier.

Configuration is written one 19-bit gene per clock into a staging bank, addressed by unit number. A commit strobe then copies the whole staging bank into the live bank in a single cycle. Candidates therefore switch over atomically, and a partly written candidate is never evaluated. Once the live bank is set, the path from the operands to the result has no registers.

Top module: `evoarr_top`

## Requirements
- R1: A synchronous active-low reset clears both configuration banks to all-zero genes. As a result, `prod` equals `op_x[0]` copied onto all eight bits.
- R2: When `cfg_we` is high and `cfg_addr` is below 22, `cfg_gene` is stored as the staged gene of that unit on the clock edge. Writes to addresses 22 to 31 change nothing.
- R3: Staged genes have no effect on `prod` until `cfg_done` is sampled high. On that edge, all 22 staged genes become live together.
- R4: Gene layout: bit 18 selects the function (1 = adder, 0 = AND). Bits 17:9 hold the second operand field and bits 8:0 hold the first. Within an operand field, bits 8:4 are the source slot, bit 3 selects single-bit mode, bits 2:1 give the bit position, and bit 0 selects the upper window.
- R5: Source slots 0-3 carry `op_x` and slots 4-7 carry `op_y`. Slot 8 is the constant 4'b0001 and slot 9 is zero. Unit k occupies slot 10+k. Primary slots read as 5-bit values with a zero MSB.
- R6: A unit at slot s may read only slots below s. Any source slot at or above s is treated as slot s-1.
- R7: In single-bit mode, the selected bit of the windowed 4-bit source drives all four operand lanes. Otherwise the whole windowed bus is used.
- R8: The upper window reads bits 4:1 of the 5-bit source and the lower window reads bits 3:0. This applies to AND results, adder results and primary slots.
- R9: An AND unit yields the bitwise AND of its operands, and its result bit 4 is 0.
- R10: An adder unit yields the 4-bit sum with carry-in 0, and the final carry forms result bit 4.
- R11: Units 14 to 21 each drive `prod[k-14]` with bit 0 of their routed first operand. Their function bit and second operand field have no effect on that bit.
- R12: `prod` follows changes on `op_x` and `op_y` within the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Stage one gene this cycle |
| cfg_addr | input | 5 | Unit number of the staged gene |
| cfg_gene | input | 19 | Gene value to stage |
| cfg_done | input | 1 | Commit the staging bank to the live bank |
| op_x | input | 4 | First primary operand |
| op_y | input | 4 | Second primary operand |
| prod | output | 8 | Tap outputs (product bits) |

## Verification
The only internal state is the two gene banks. A wrong staged gene stays invisible until the next commit. After that commit, the result port shows it at once, for the very next operand pair that exercises the affected unit. A live gene that is wrong, or one that changes without a commit, alters `prod` combinationally, so the error appears in the same cycle as the operands that expose it. An exhaustive sweep over all 256 operand pairs of a multiplier configuration catches any routing, window or function error on the used path. Single-unit probe configurations expose all five result bits of one unit, which lets clamping, constants, fan-out and carry be checked one at a time.

// File: rtl/evoarr_pkg.sv
// Shared sizes and gene types for the bus-level evolvable array.
// Assumes lane width is a power of two and the slot count fits IDX_W bits.
package evoarr_pkg;
    parameter int LANE_W = 4;   // bus width of every unit
    parameter int COPIES = 4;   // duplicated slots per primary operand
    parameter int UNITS  = 22;  // configurable units
    parameter int TAPS   = 8;   // trailing units that drive result bits

    localparam int PRIM_SLOTS = 2 * COPIES + 2;
    localparam int SLOTS      = PRIM_SLOTS + UNITS;
    localparam int IDX_W      = $clog2(SLOTS);
    localparam int POS_W      = $clog2(LANE_W);
    localparam int RES_W      = LANE_W + 1;
    localparam int UADDR_W    = $clog2(UNITS);
    localparam int ONE_SLOT   = 2 * COPIES;
    localparam int ZERO_SLOT  = 2 * COPIES + 1;

    // Routing selection for one operand.
    typedef struct packed {
        logic [IDX_W-1:0] idx;    // source slot
        logic             fan;    // single-bit mode
        logic [POS_W-1:0] pos;    // bit inside window
        logic             upper;  // upper window of the 5-bit source
    } opsel_t;

    // Complete gene of one unit.
    typedef struct packed {
        logic   is_add;
        opsel_t b;
        opsel_t a;
    } gene_t;

    localparam int GENE_W = $bits(gene_t);
endpackage

// File: rtl/evoarr_cfg_store.sv
// Two-bank gene storage: a staging bank written one gene per cycle and a
// live bank loaded from it in one cycle on commit. Assumes out-of-range
// addresses are to be dropped.
module evoarr_cfg_store
    import evoarr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [UADDR_W-1:0]              addr_i,
    input  logic [GENE_W-1:0]               gene_i,
    input  logic                            commit_i,
    output logic [UNITS-1:0][GENE_W-1:0]    active_o
);
    logic [UNITS-1:0][GENE_W-1:0] shadow_q;
    logic [UNITS-1:0][GENE_W-1:0] active_q;
    logic                         addr_ok;

    // Address range qualifier for staging writes.
    always_comb addr_ok = (int'(addr_i) < UNITS);

    // Staging bank: one gene per write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (we_i && addr_ok)
            shadow_q[addr_i] <= gene_i;
    end

    // Live bank: whole-bank copy on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (commit_i)
            active_q <= shadow_q;
    end

    assign active_o = active_q;

    // R2: staged gene lands at its address.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_ok) |=> shadow_q[$past(addr_i)] == $past(gene_i));

    // R2: out-of-range write leaves staging untouched.
    assert_oob_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !addr_ok) |=> $stable(shadow_q));

    // R3: live bank only moves on commit.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(active_q));

    // R3: commit transfers the staging bank as it stood.
    assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> active_q == $past(shadow_q));
endmodule

// File: rtl/evoarr_route.sv
// Operand router: picks one of the visible slots (clamped feed-forward),
// applies the upper/lower window and optional single-bit fan-out.
// Assumes VISIBLE is the unit's own slot number (only lower slots visible).
module evoarr_route
    import evoarr_pkg::*;
#(
    parameter int VISIBLE = 1
)
(
    input  logic [VISIBLE*RES_W-1:0] pool_i,
    input  opsel_t                   sel_i,
    output logic [LANE_W-1:0]        op_o
);
    localparam int TOP_IDX = VISIBLE - 1;

    logic [IDX_W-1:0]  eff_idx;
    logic [RES_W-1:0]  word;
    logic [LANE_W-1:0] win;

    // Clamp any forward or self reference to the highest visible slot.
    always_comb eff_idx = (int'(sel_i.idx) > TOP_IDX) ? IDX_W'(TOP_IDX) : sel_i.idx;

    // Fetch the 5-bit source word.
    always_comb word = pool_i[int'(eff_idx)*RES_W +: RES_W];

    // Choose upper or lower 4-bit window.
    always_comb win = sel_i.upper ? word[RES_W-1:1] : word[LANE_W-1:0];

    // Whole bus or one bit copied to all lanes.
    always_comb op_o = sel_i.fan ? {LANE_W{win[sel_i.pos]}} : win;
endmodule

// File: rtl/evoarr_unit.sv
// Functional unit: bitwise AND (MSB forced low) or ripple adder with
// carry-in zero whose final carry becomes the MSB.
module evoarr_unit
    import evoarr_pkg::*;
(
    input  logic              is_add_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    output logic [RES_W-1:0]  res_o
);
    logic [LANE_W-1:0] sum;
    logic [LANE_W:0]   cy;

    // Ripple-carry chain, bit by bit.
    always_comb begin
        cy[0] = 1'b0;
        for (int i = 0; i < LANE_W; i++) begin
            sum[i]  = a_i[i] ^ b_i[i] ^ cy[i];
            cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
        end
    end

    // Function select.
    always_comb res_o = is_add_i ? {cy[LANE_W], sum} : {1'b0, a_i & b_i};
endmodule

// File: rtl/evoarr_top.sv
// Bus-level evolvable array top: gene storage, primary slot pool, a
// feed-forward chain of configurable units, and result taps on the last
// TAPS units. Assumes inputs op_x/op_y are settled while prod is used.
module evoarr_top
    import evoarr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [UADDR_W-1:0] cfg_addr,
    input  logic [GENE_W-1:0]  cfg_gene,
    input  logic               cfg_done,
    input  logic [LANE_W-1:0]  op_x,
    input  logic [LANE_W-1:0]  op_y,
    output logic [TAPS-1:0]    prod
);
    localparam int TAP_BASE = UNITS - TAPS;

    logic [UNITS-1:0][GENE_W-1:0] live;
    logic [SLOTS*RES_W-1:0]       pool;

    evoarr_cfg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .addr_i   (cfg_addr),
        .gene_i   (cfg_gene),
        .commit_i (cfg_done),
        .active_o (live)
    );

    // Primary slots: duplicated operands, then the two constants.
    for (genvar p = 0; p < COPIES; p++) begin : g_prim
        assign pool[p*RES_W +: RES_W]            = {1'b0, op_x};
        assign pool[(COPIES+p)*RES_W +: RES_W]   = {1'b0, op_y};
    end
    assign pool[ONE_SLOT*RES_W +: RES_W]  = RES_W'(1);
    assign pool[ZERO_SLOT*RES_W +: RES_W] = '0;

    // Feed-forward chain of units; each sees only the slots below it.
    for (genvar k = 0; k < UNITS; k++) begin : g_unit
        localparam int SLOT = PRIM_SLOTS + k;
        gene_t             g;
        logic [LANE_W-1:0] a_op;
        logic [LANE_W-1:0] b_op;
        logic [RES_W-1:0]  res;

        assign g = gene_t'(live[k]);

        evoarr_route #(.VISIBLE(SLOT)) u_route_a (
            .pool_i (pool[SLOT*RES_W-1:0]),
            .sel_i  (g.a),
            .op_o   (a_op)
        );

        evoarr_route #(.VISIBLE(SLOT)) u_route_b (
            .pool_i (pool[SLOT*RES_W-1:0]),
            .sel_i  (g.b),
            .op_o   (b_op)
        );

        evoarr_unit u_fn (
            .is_add_i (g.is_add),
            .a_i      (a_op),
            .b_i      (b_op),
            .res_o    (res)
        );

        assign pool[SLOT*RES_W +: RES_W] = res;

        // Trailing units drive one result bit each from their first operand.
        if (k >= TAP_BASE) begin : g_tap
            assign prod[k-TAP_BASE] = a_op[0];
        end

        // R9: AND results never set the top bit.
        assert_and_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !g.is_add |-> !res[RES_W-1]);

        // R7: single-bit mode yields identical lanes.
        assert_fanout_R7: assert property (@(posedge clk) disable iff (!rst_n)
            g.a.fan |-> ($countones(a_op) == 0 || $countones(a_op) == LANE_W));
    end
endmodule

// File: tb/test_evoarr_top.sv
// Directed bench for evoarr_top: one task per scenario, each self-checking.
module test_evoarr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [18:0] cfg_gene = '0;
    logic        cfg_done = 1'b0;
    logic [3:0]  op_x = '0;
    logic [3:0]  op_y = '0;
    logic [7:0]  prod;

    int n_chk = 0;
    int n_bad = 0;
    logic [18:0] mul_genes [22];

    always #4 clk = ~clk;

    evoarr_top i_evoarr_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_gene(cfg_gene), .cfg_done(cfg_done), .op_x(op_x), .op_y(op_y),
        .prod(prod)
    );

    // Operand field per R4: {slot[4:0], fan, pos[1:0], upper}.
    function automatic logic [8:0] opf(int idx, bit fan, int pos, bit hi);
        return {5'(idx), fan, 2'(pos), hi};
    endfunction

    // Gene per R4: {is_add, second[8:0], first[8:0]}.
    function automatic logic [18:0] mk(bit add, logic [8:0] b, logic [8:0] a);
        return {add, b, a};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [18:0] g);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_gene = g;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    // Drive operands just after a falling edge, sample 1 ns later (R12).
    task automatic apply(int x, int y);
        @(negedge clk);
        op_x = 4'(x); op_y = 4'(y);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply(5, 0);  check("R1 reset x0=1", prod, 8'hFF);
        apply(4, 9);  check("R1 reset x0=0", prod, 8'h00);
    endtask

    task automatic build_mul();
        for (int i = 0; i < 22; i++) mul_genes[i] = '0;
        for (int i = 0; i < 4; i++)
            mul_genes[i] = mk(0, opf(4+i, 1, i, 0), opf(i, 0, 0, 0));
        mul_genes[4] = mk(1, opf(11, 0, 0, 0), opf(10, 0, 0, 1));
        mul_genes[5] = mk(1, opf(12, 0, 0, 0), opf(14, 0, 0, 1));
        mul_genes[6] = mk(1, opf(13, 0, 0, 0), opf(15, 0, 0, 1));
        mul_genes[14] = mk(0, '0, opf(10, 0, 0, 0));
        mul_genes[15] = mk(0, '0, opf(14, 0, 0, 0));
        mul_genes[16] = mk(0, '0, opf(15, 0, 0, 0));
        mul_genes[17] = mk(0, '0, opf(16, 0, 0, 0));
        mul_genes[18] = mk(0, '0, opf(16, 0, 0, 1));
        for (int i = 1; i < 4; i++)
            mul_genes[18+i] = mk(0, '0, opf(16, 1, i, 1));
    endtask

    task automatic t_multiplier();
        build_mul();
        for (int i = 0; i < 22; i++) wr(i, mul_genes[i]);
        apply(7, 2); check("R3 staged not live", prod, 8'hFF);
        commit();
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
                apply(x, y);
                check("R4/R12 product", prod, 8'(x * y));
            end
    endtask

    task automatic t_staging();
        wr(0, '0);
        apply(13, 11); check("R3 pending write", prod, 8'd143);
        wr(0, mul_genes[0]);
        wr(22, 19'h7FFFF);
        wr(31, 19'h7FFFF);
        commit();
        apply(13, 11); check("R2 oob ignored a", prod, 8'd143);
        apply(15, 15); check("R2 oob ignored b", prod, 8'd225);
    endtask

    // Probe: taps 0..4 show unit 0's 5-bit result, taps 5..7 unit 1 bits 0..2.
    // Tap genes carry an adder function and a junk second operand (R11).
    task automatic setup_probe();
        for (int i = 0; i < 14; i++) wr(i, '0);
        for (int i = 0; i < 4; i++) wr(14+i, mk(1, opf(5, 1, 3, 1), opf(10, 1, i, 0)));
        wr(18, mk(1, opf(5, 1, 3, 1), opf(10, 1, 3, 1)));
        for (int i = 0; i < 3; i++) wr(19+i, mk(1, opf(5, 1, 3, 1), opf(11, 1, i, 0)));
    endtask

    task automatic probe(string tag, logic [18:0] g0, int x, int y, int r);
        logic [3:0] xv;
        wr(0, g0);
        commit();
        apply(x, y);
        xv = 4'(x);
        check(tag, prod, {xv[2:0], 5'(r)});
    endtask

    task automatic t_units();
        setup_probe();
        probe("R10 add 15+15", mk(1, opf(4,0,0,0), opf(0,0,0,0)), 15, 15, 30);
        probe("R10 add 9+8",   mk(1, opf(4,0,0,0), opf(0,0,0,0)), 9, 8, 17);
        probe("R11 tap ignores fn/b", mk(1, opf(4,0,0,0), opf(0,0,0,0)), 7, 1, 8);
        probe("R9 and 12&10",  mk(0, opf(5,0,0,0), opf(1,0,0,0)), 12, 10, 8);
        probe("R9 and 15&15",  mk(0, opf(5,0,0,0), opf(1,0,0,0)), 15, 15, 15);
        probe("R7 fan bit set",   mk(0, opf(6,1,2,0), opf(2,0,0,0)), 11, 4, 11);
        probe("R7 fan bit clear", mk(0, opf(6,1,2,0), opf(2,0,0,0)), 11, 3, 0);
        probe("R8 upper window",  mk(1, opf(7,0,0,0), opf(3,0,0,1)), 15, 15, 22);
        probe("R5 const one+zero", mk(1, opf(9,0,0,0), opf(8,0,0,0)), 6, 6, 1);
        probe("R5 const fan+bus",  mk(1, opf(8,1,0,0), opf(8,0,0,0)), 2, 2, 16);
        probe("R6 clamp slot 31",  mk(1, opf(8,0,0,0), opf(31,0,0,0)), 15, 15, 1);
        probe("R6 clamp self",     mk(1, opf(10,0,0,0), opf(8,0,0,0)), 12, 12, 1);
        probe("R6 clamp fan",      mk(1, opf(20,1,0,0), opf(0,0,0,0)), 13, 5, 13);
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(3, 15); check("R1 reset after run", prod, 8'hFF);
    endtask

    initial begin
        t_reset();
        t_multiplier();
        t_staging();
        t_units();
        t_rereset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule